// File: doc/BRIEF.md
# Multi-Mode Timer Counter With Selectable Length

This block is a timer counter clocked by one common system clock. Four tick inputs arrive as one-cycle enable pulses, and a select field picks one of them. The chosen tick goes through a power-of-two prescaler. Every Nth selected tick advances a counter. The counter's largest value comes from a length field of 8, 10, 12 or 16 bits.

A two-bit mode field picks one of four behaviours: halt, count up to a compare value, count up over the full length, or count up and down between zero and the compare value. When the compare value is larger than the current length maximum, the limit behaves differently: the up mode drops to zero on every step, and the up/down mode acts like continuous counting.

A one-cycle clear request zeroes the counter, the prescaler and the direction. The outputs are the count, a one-cycle wrap pulse and a direction flag.

Top module: `mtc_timer`

## Requirements
- R1: While reset is asserted and after it is released, `count` is 0, `wrap` is 0 and `dir_down` is 0 until the first counter step.
- R2: With `mode` = 00 (halt), neither the counter nor the prescaler changes, whatever the tick inputs do.
- R3: With `mode` = 10 (continuous), each step adds one until the length maximum is reached, and the next step gives 0. `len_sel` 00, 01, 10 and 11 give maxima of 0xFF, 0x3FF, 0xFFF and 0xFFFF.
- R4: `wrap` is high for exactly the one cycle after a step that takes the count from a nonzero value to 0, in every mode. A step from 0 to 0 gives no pulse.
- R5: With `mode` = 01 (up to compare), the count climbs to `cmp_val` and the next step gives 0. If `cmp_val` exceeds the length maximum, every step gives 0.
- R6: With `mode` = 11 (up/down), the count climbs to `cmp_val`, then falls one per step to 0, and then repeats. `dir_down` is 1 while the count is falling and not yet at 0, and 0 otherwise. In any other mode `dir_down` is 0, so entering mode 11 always starts with an upward count.
- R7: In mode 11, if `cmp_val` exceeds the length maximum, the counter behaves as in mode 10: it goes from the maximum straight to 0, and `dir_down` stays 0.
- R8: `div_sel` 00, 01, 10 and 11 make the counter step once per 1, 2, 4 or 8 selected tick pulses.
- R9: `src_sel` = k selects `tick_in[k]`. Pulses on the other tick inputs have no effect.
- R10: A cycle with `clr` high zeroes the counter, the prescaler, `dir_down` and `wrap` on the next edge, whatever the mode. Counting then resumes upward.
- R11: If `len_sel` changes while the count is above the new maximum, the next step works from the count masked to the new width. For example, 300 at length 16 becomes 45 at length 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 4 | One-cycle tick enables, one per source |
| src_sel | input | 2 | Tick source select |
| div_sel | input | 2 | Prescaler ratio code |
| mode | input | 2 | Counting mode |
| len_sel | input | 2 | Counter length code |
| cmp_val | input | 16 | Compare limit |
| clr | input | 1 | Clear request, one cycle per clear |
| count | output | 16 | Counter value |
| wrap | output | 1 | One-cycle pulse when the count returns to 0 |
| dir_down | output | 1 | 1 while counting down in up/down mode |

## Verification
The hardest state to reach from the ports is an out-of-range compare value or a reduced length at the moment the count sits near a turning point. This happens, for example, when the length shrinks while the count is above the new maximum, or when an up/down sweep is falling and the mode changes. Directed sequences drive the count to such values at the maximum tick rate before changing the configuration. Randomized segments then reconfigure the mode, length, ratio, source and compare value while the counter is in motion, with sparse clear pulses, so that these transitions happen at arbitrary phases of the prescaler.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  typedef enum logic [1:0] {
    MODE_HALT = 2'b00,
    MODE_UP   = 2'b01,
    MODE_CONT = 2'b10,
    MODE_UPDN = 2'b11
  } mtc_mode_e;

  typedef enum logic [1:0] {
    LEN_A = 2'b00,
    LEN_B = 2'b01,
    LEN_C = 2'b10,
    LEN_D = 2'b11
  } mtc_len_e;
endpackage

// File: rtl/mtc_tick_sel.sv
module mtc_tick_sel #(
  parameter int N_SRC = 4,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] tick_in,
  input  logic [SEL_W-1:0] src_sel,
  output logic             tick
);
  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (src_sel == SEL_W'(i)) tick = tick_in[i];
    end
  end
endmodule

// File: rtl/mtc_prescaler.sv
module mtc_prescaler #(
  parameter int DIV_W = 2,
  localparam int PRE_W = (1 << DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic [DIV_W-1:0] div_sel,
  output logic             adv
);
  logic [PRE_W-1:0] pre_q, pre_d, pre_lim;
  logic             pre_en;

  always_comb begin
    pre_lim = PRE_W'((32'd1 << div_sel) - 32'd1);
    pre_d   = pre_q;
    adv     = 1'b0;
    pre_en  = 1'b0;
    if (clr) begin
      pre_d  = '0;
      pre_en = 1'b1;
    end else if (run && tick) begin
      pre_en = 1'b1;
      if (pre_q >= pre_lim) begin
        pre_d = '0;
        adv   = 1'b1;
      end else begin
        pre_d = pre_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end
endmodule

// File: rtl/mtc_counter.sv
module mtc_counter
  import mtc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int LA_BITS = 8,
  parameter int LB_BITS = 10,
  parameter int LC_BITS = 12,
  parameter int LD_BITS = CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  mtc_mode_e        mode,
  input  mtc_len_e         len_sel,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             dir_down
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_m, lim;
  logic             dn_q, dn_d, wrap_q, wrap_d, cnt_en, cmp_over;
  int unsigned      len_bits;

  always_comb begin
    unique case (len_sel)
      LEN_A:   len_bits = LA_BITS;
      LEN_B:   len_bits = LB_BITS;
      LEN_C:   len_bits = LC_BITS;
      default: len_bits = LD_BITS;
    endcase
    lim      = CNT_W'((33'd1 << len_bits) - 33'd1);
    cnt_m    = cnt_q & lim;
    cmp_over = cmp_val > lim;
  end

  always_comb begin
    cnt_d  = cnt_q;
    dn_d   = (mode == MODE_UPDN) ? dn_q : 1'b0;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      dn_d   = 1'b0;
      cnt_en = 1'b1;
    end else if (adv) begin
      cnt_en = 1'b1;
      unique case (mode)
        MODE_UP:   cnt_d = (cmp_over || cnt_m >= cmp_val) ? '0 : cnt_m + CNT_W'(1);
        MODE_CONT: cnt_d = (cnt_m == lim) ? '0 : cnt_m + CNT_W'(1);
        MODE_UPDN: begin
          if (cmp_over) begin
            cnt_d = (cnt_m == lim) ? '0 : cnt_m + CNT_W'(1);
            dn_d  = 1'b0;
          end else if (dn_q || cnt_m >= cmp_val) begin
            cnt_d = (cnt_m == '0) ? '0 : cnt_m - CNT_W'(1);
            dn_d  = (cnt_d != '0);
          end else begin
            cnt_d = cnt_m + CNT_W'(1);
          end
        end
        default:   cnt_d = cnt_q;
      endcase
    end
    wrap_d = !clr && adv && (cnt_m != '0) && (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_q   <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      dn_q   <= dn_d;
      wrap_q <= wrap_d;
    end
  end

  assign count    = cnt_q;
  assign wrap     = wrap_q;
  assign dir_down = dn_q;
endmodule

// File: rtl/mtc_timer.sv
module mtc_timer
  import mtc_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int CNT_W = 16,
  parameter int DIV_W = 2,
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] tick_in,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [1:0]       mode,
  input  logic [1:0]       len_sel,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             dir_down
);
  logic      sel_tick, adv, run;
  mtc_mode_e mode_e;

  assign mode_e = mtc_mode_e'(mode);
  assign run    = (mode_e != MODE_HALT);

  mtc_tick_sel #(.N_SRC(N_SRC)) u_sel (
    .tick_in (tick_in),
    .src_sel (src_sel),
    .tick    (sel_tick)
  );

  mtc_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .run     (run),
    .tick    (sel_tick),
    .div_sel (div_sel),
    .adv     (adv)
  );

  mtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .adv      (adv),
    .mode     (mode_e),
    .len_sel  (mtc_len_e'(len_sel)),
    .cmp_val  (cmp_val),
    .count    (count),
    .wrap     (wrap),
    .dir_down (dir_down)
  );
endmodule

// File: rtl/mtc_timer_chk.sv
module mtc_timer_chk #(
  parameter int N_SRC = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] tick_in,
  input logic [1:0]       mode,
  input logic             clr,
  input logic [CNT_W-1:0] count,
  input logic             wrap,
  input logic             dir_down
);
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !clr) |=> $stable(count)); // R2

  AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_in == '0 && !clr) |=> $stable(count)); // R9

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && !dir_down && !wrap)); // R10

  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (count == '0)); // R4

  AST_DIR_ONLY_UPDN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b11) |=> !dir_down); // R6

  AST_DIR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dir_down |-> (count != '0)); // R6
endmodule

bind mtc_timer mtc_timer_chk #(.N_SRC(N_SRC), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_in  (tick_in),
  .mode     (mode),
  .clr      (clr),
  .count    (count),
  .wrap     (wrap),
  .dir_down (dir_down)
);

// File: tb/mtc_timer_bench.sv
`timescale 1ns/1ps
module mtc_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tick_in = '0;
  logic [1:0]  src_sel = '0, div_sel = '0, mode = '0, len_sel = '0;
  logic [15:0] cmp_val = '0;
  logic        clr = 1'b0;
  logic [15:0] count;
  logic        wrap, dir_down;

  int    n_run = 0, n_fail = 0;
  bit    chk_en = 1'b0, done = 1'b0;
  string tag = "R1";

  logic [15:0] m_cnt;
  int          m_pre;
  logic        m_down, m_wrap;

  always #2 clk = ~clk;

  mtc_timer u_mtc_timer (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .src_sel(src_sel),
    .div_sel(div_sel), .mode(mode), .len_sel(len_sel), .cmp_val(cmp_val),
    .clr(clr), .count(count), .wrap(wrap), .dir_down(dir_down)
  );

  function automatic logic [15:0] f_max(logic [1:0] l);
    case (l)
      2'b00:   return 16'h00FF;
      2'b01:   return 16'h03FF;
      2'b10:   return 16'h0FFF;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic int f_ratio(logic [1:0] d);
    return 1 << d;
  endfunction

  // Reference model written from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_pre = 0; m_down = 1'b0; m_wrap = 1'b0;
    end else begin
      logic [15:0] mx, c, n;
      m_wrap = 1'b0;
      mx = f_max(len_sel);
      if (clr) begin
        m_cnt = '0; m_pre = 0; m_down = 1'b0;
      end else begin
        if (mode != 2'b11) m_down = 1'b0;
        if (mode != 2'b00 && tick_in[src_sel]) begin
          if (m_pre >= f_ratio(div_sel) - 1) begin
            m_pre = 0;
            c = m_cnt & mx;
            n = c;
            case (mode)
              2'b01: n = (cmp_val > mx || c >= cmp_val) ? 16'd0 : c + 16'd1;
              2'b10: n = (c == mx) ? 16'd0 : c + 16'd1;
              default: begin
                if (cmp_val > mx) begin
                  n = (c == mx) ? 16'd0 : c + 16'd1;
                  m_down = 1'b0;
                end else if (m_down || c >= cmp_val) begin
                  n = (c == 0) ? 16'd0 : c - 16'd1;
                  m_down = (n != 0);
                end else n = c + 16'd1;
              end
            endcase
            m_wrap = (c != 0) && (n == 0);
            m_cnt = n;
          end else m_pre = m_pre + 1;
        end
      end
    end
  end

  task automatic check(string t, logic [15:0] act, logic [15:0] exp, string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      check(tag, count, m_cnt, "count");
      check(tag, {15'd0, wrap}, {15'd0, m_wrap}, "wrap");
      check(tag, {15'd0, dir_down}, {15'd0, m_down}, "dir_down");
    end
  end

  task automatic cyc(int n, int pct, logic [3:0] msk = 4'hF);
    for (int i = 0; i < n; i++) begin
      logic [3:0] t;
      for (int b = 0; b < 4; b++) t[b] = (($urandom % 100) < pct);
      tick_in = t & msk;
      @(negedge clk);
    end
  endtask

  task automatic do_clr();
    clr = 1'b1; cyc(1, 0); clr = 1'b0;
  endtask

  task automatic cfg(logic [1:0] m, logic [1:0] l, logic [1:0] d, logic [1:0] s, logic [15:0] c);
    mode = m; len_sel = l; div_sel = d; src_sel = s; cmp_val = c;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", count, 16'd0, "count in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_en = 1'b1;
    check("R1", {15'd0, wrap}, 16'd0, "wrap after reset");

    tag = "R3"; cfg(2'b10, 2'b00, 2'b00, 2'b00, 16'd0); do_clr();
    cyc(255, 100);
    check("R3", count, 16'd255, "cont 8-bit top");
    cyc(1, 100);
    check("R3", count, 16'd0, "cont 8-bit wrap");
    check("R4", {15'd0, wrap}, 16'd1, "wrap pulse");
    cyc(1, 100);
    check("R4", {15'd0, wrap}, 16'd0, "wrap one cycle");

    tag = "R5"; cfg(2'b01, 2'b00, 2'b00, 2'b00, 16'd5); do_clr();
    cyc(5, 100); check("R5", count, 16'd5, "up at cmp");
    cyc(1, 100); check("R5", count, 16'd0, "up restart");
    cmp_val = 16'd300; do_clr(); cyc(10, 100);
    check("R5", count, 16'd0, "cmp above length max");

    tag = "R6"; cfg(2'b11, 2'b00, 2'b00, 2'b00, 16'd3); do_clr();
    cyc(3, 100); check("R6", {15'd0, dir_down}, 16'd0, "dir at top");
    cyc(1, 100); check("R6", count, 16'd2, "first down step");
    check("R6", {15'd0, dir_down}, 16'd1, "dir falling");
    cyc(2, 100); check("R6", count, 16'd0, "bottom");
    check("R6", {15'd0, dir_down}, 16'd0, "dir at zero");

    tag = "R7"; cmp_val = 16'd300; do_clr(); cyc(255, 100);
    check("R7", count, 16'd255, "updn over at max");
    cyc(1, 100); check("R7", count, 16'd0, "updn over wraps");
    check("R7", {15'd0, dir_down}, 16'd0, "no down");

    tag = "R8"; cfg(2'b10, 2'b11, 2'b10, 2'b00, 16'd0); do_clr();
    cyc(8, 100); check("R8", count, 16'd2, "divide by 4");
    div_sel = 2'b11; do_clr(); cyc(16, 100);
    check("R8", count, 16'd2, "divide by 8");

    tag = "R9"; cfg(2'b10, 2'b11, 2'b00, 2'b10, 16'd0); do_clr();
    cyc(20, 100, 4'b1011); check("R9", count, 16'd0, "unselected ticks");
    cyc(7, 100, 4'b0100); check("R9", count, 16'd7, "selected tick");

    tag = "R2"; mode = 2'b00; cyc(20, 100);
    check("R2", count, 16'd7, "halt holds");

    tag = "R10"; mode = 2'b10; do_clr();
    check("R10", count, 16'd0, "clear zeroes");

    tag = "R11"; cfg(2'b10, 2'b11, 2'b00, 2'b00, 16'd0); do_clr();
    cyc(300, 100); check("R11", count, 16'd300, "count at 300");
    len_sel = 2'b00; cyc(1, 100);
    check("R11", count, 16'd45, "masked after length change");

    tag = "R4";
    for (int k = 0; k < 40; k++) begin
      cfg(2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
          ($urandom % 2) ? 16'($urandom % 20) : 16'($urandom));
      if ($urandom % 4 == 0) do_clr();
      cyc(300, 20 + int'($urandom % 81));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule